// File: doc/BRIEF.md
# Execution Count Break Counter

This block is the counting stage of one debug break channel. Software loads a count through a 16-bit register port. The channel's comparator sends a strobe each time its break condition matches. While the count-break feature is enabled, every strobe lowers the count by one. The strobe that arrives while the count is exactly one raises a single-cycle break request. That strobe also takes the count to zero, and the count then stays at zero until software writes a new value.

The counter is read back through the same register port, and the current count is always visible. Only the low twelve bits hold the count, so the largest programmable value is 4095. The upper four bits are reserved and read as zero. The register port, the strobe and the enable are plain control signals. None of them carries a stream, so there is no valid/ready handshake and no back-pressure.

Top module: `exec_count_break`

## Requirements
- R1: After reset the register reads 0x0000 and `brk_req` is low.
- R2: A write with `reg_wr` high loads `reg_wdata[11:0]` into the count on that clock edge. `reg_rdata[11:0]` shows the count, and `reg_rdata[15:12]` always reads zero whatever was written there. Without a write or a counted match, the count holds.
- R3: A match (`match_strb` high with `cnt_en` high and no write) while the count is 2 or more lowers the count by exactly one and raises no break.
- R4: A match while the count is 1 sets the count to 0 and drives `brk_req` high for the cycle after the edge that sampled the match.
- R5: A match while the count is 0 leaves the count at 0 and raises no break. This covers a programmed count of zero and every match after a break.
- R6: With `cnt_en` low, `match_strb` changes neither the count nor `brk_req`.
- R7: When a write and a match come in the same cycle, the written value is loaded and the match is dropped: no decrement and no break.
- R8: `brk_req` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data; bits 11:0 are the count |
| reg_rdata | output | 16 | Current register value; bits 15:12 are zero |
| match_strb | input | 1 | One pulse per break-condition match from the comparator |
| cnt_en | input | 1 | Count-break enable for the channel |
| brk_req | output | 1 | One-cycle break request |

## Verification
The bench goes after the transition from one to zero. A design that fires when the count reaches zero breaks one match late, and a design that fires on every match at zero repeats the break without end. Programmed zero, writes that collide with matches, writes with the reserved bits set, and matches with the enable low are driven directly and also mixed in at random. A design that lets the decrement win over the write, stores the reserved bits, or counts with the enable low then shows a count one off or a stray nibble on readback.

// File: rtl/ecb_pkg.sv
package ecb_pkg;
  localparam int unsigned ECB_CNT_W = 12;
  localparam int unsigned ECB_REG_W = 16;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_LOAD = 2'd1,
    ACT_DEC  = 2'd2,
    ACT_FIRE = 2'd3
  } ecb_act_e;
endpackage

// File: rtl/ecb_ctrl.sv
module ecb_ctrl #(
  parameter int unsigned REG_W = ecb_pkg::ECB_REG_W
) (
  input  logic                 wr_i,
  input  logic                 match_i,
  input  logic                 en_i,
  input  logic [REG_W-1:0]     cnt_i,
  output ecb_pkg::ecb_act_e    act_o
);
  import ecb_pkg::*;

  logic cnt_zero;
  logic cnt_one;

  assign cnt_zero = (cnt_i == '0);
  assign cnt_one  = (cnt_i == REG_W'(1));

  // Write outranks a match; a match only counts while enabled.
  always_comb begin
    act_o = ACT_HOLD;
    if (wr_i)                       act_o = ACT_LOAD;
    else if (match_i && en_i) begin
      if (cnt_one)                  act_o = ACT_FIRE;
      else if (!cnt_zero)           act_o = ACT_DEC;
    end
  end
endmodule

// File: rtl/ecb_counter.sv
module ecb_counter #(
  parameter int unsigned CNT_W = ecb_pkg::ECB_CNT_W,
  parameter int unsigned REG_W = ecb_pkg::ECB_REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ecb_pkg::ecb_act_e act_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  cnt_o
);
  import ecb_pkg::*;

  localparam logic [REG_W-1:0] FIELD_MASK = REG_W'((64'd1 << CNT_W) - 64'd1);

  logic [REG_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else begin
      unique case (act_i)
        ACT_LOAD:          cnt_q <= wdata_i & FIELD_MASK;
        ACT_DEC, ACT_FIRE: cnt_q <= cnt_q - REG_W'(1);
        default:           cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ecb_pulse.sv
module ecb_pulse (
  input  logic              clk,
  input  logic              rst_n,
  input  ecb_pkg::ecb_act_e act_i,
  output logic              brk_o
);
  import ecb_pkg::*;

  logic brk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) brk_q <= 1'b0;
    else        brk_q <= (act_i == ACT_FIRE);
  end

  assign brk_o = brk_q;
endmodule

// File: rtl/exec_count_break.sv
module exec_count_break #(
  parameter int unsigned CNT_W = ecb_pkg::ECB_CNT_W,
  parameter int unsigned REG_W = ecb_pkg::ECB_REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             match_strb,
  input  logic             cnt_en,
  output logic             brk_req
);
  import ecb_pkg::*;

  ecb_act_e         act;
  logic [REG_W-1:0] cnt;

  ecb_ctrl #(.REG_W(REG_W)) u_ctrl (
    .wr_i    (reg_wr),
    .match_i (match_strb),
    .en_i    (cnt_en),
    .cnt_i   (cnt),
    .act_o   (act)
  );

  ecb_counter #(.CNT_W(CNT_W), .REG_W(REG_W)) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .act_i   (act),
    .wdata_i (reg_wdata),
    .cnt_o   (cnt)
  );

  ecb_pulse u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .act_i (act),
    .brk_o (brk_req)
  );

  assign reg_rdata = cnt;
endmodule

// File: rtl/ecb_checker.sv
module ecb_checker #(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned REG_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [REG_W-1:0] reg_wdata,
  input logic [REG_W-1:0] reg_rdata,
  input logic             match_strb,
  input logic             cnt_en,
  input logic             brk_req
);
  localparam logic [REG_W-1:0] FIELD_MASK = REG_W'((64'd1 << CNT_W) - 64'd1);

  logic counted;
  assign counted = match_strb && cnt_en && !reg_wr;

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~FIELD_MASK) == '0);

  assert_write_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> reg_rdata == ($past(reg_wdata) & FIELD_MASK));

  assert_decrement_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (counted && reg_rdata > REG_W'(1)) |=> (reg_rdata == $past(reg_rdata) - REG_W'(1)) && !brk_req);

  assert_fire_on_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (counted && reg_rdata == REG_W'(1)) |=> brk_req && reg_rdata == '0);

  assert_zero_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata == '0 && !reg_wr) |=> !brk_req && reg_rdata == '0);

  assert_disabled_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !reg_wr) |=> $stable(reg_rdata) && !brk_req);

  assert_write_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !brk_req);

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |=> !brk_req);
endmodule

bind exec_count_break ecb_checker #(.CNT_W(CNT_W), .REG_W(REG_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .match_strb (match_strb),
  .cnt_en     (cnt_en),
  .brk_req    (brk_req)
);

// File: tb/exec_count_break_tb.sv
module exec_count_break_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        match_strb = 1'b0;
  logic        cnt_en = 1'b0;
  logic        brk_req;

  int unsigned n_checks = 0;
  int unsigned n_fails  = 0;
  logic [15:0] m_cnt = '0;
  logic        m_brk = 1'b0;
  logic        done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  exec_count_break u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .match_strb(match_strb), .cnt_en(cnt_en),
    .brk_req(brk_req)
  );

  function automatic logic [15:0] nxt_cnt(logic [15:0] c, logic w, logic [15:0] d, logic m, logic e);
    if (w)                  return d & 16'h0FFF;
    if (m && e && c != '0)  return c - 16'd1;
    return c;
  endfunction

  function automatic logic nxt_brk(logic [15:0] c, logic w, logic m, logic e);
    return !w && m && e && (c == 16'd1);
  endfunction

  function automatic string tag_of(logic [15:0] c, logic w, logic m, logic e);
    if (w)      return (m && e) ? "R7" : "R2";
    if (!e)     return m ? "R6" : "R2";
    if (!m)     return "R2";
    if (c == 0) return "R5";
    if (c == 1) return "R4";
    return "R3";
  endfunction

  task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual 0x%04h expected 0x%04h", tag, what, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, check at the next falling edge.
  task automatic apply(logic w, logic [15:0] d, logic m, logic e);
    string t;
    logic  prev_brk;
    t = tag_of(m_cnt, w, m, e);
    prev_brk = m_brk;
    reg_wr = w; reg_wdata = d; match_strb = m; cnt_en = e;
    m_brk = nxt_brk(m_cnt, w, m, e);
    m_cnt = nxt_cnt(m_cnt, w, d, m, e);
    @(negedge clk);
    check(t, "count", reg_rdata, m_cnt);
    check((prev_brk && !m_brk) ? "R8" : t, "brk", {15'd0, brk_req}, {15'd0, m_brk});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset count", reg_rdata, 16'h0000);
    check("R1", "reset brk", {15'd0, brk_req}, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "count after release", reg_rdata, 16'h0000);

    // Directed corners
    apply(1'b0, 16'h0, 1'b1, 1'b1);          // R5 match at reset zero
    apply(1'b1, 16'hF005, 1'b0, 1'b1);       // R2 reserved bits dropped
    apply(1'b0, 16'h0, 1'b1, 1'b0);          // R6 disabled match
    apply(1'b0, 16'h0, 1'b1, 1'b1);          // R3 5->4
    apply(1'b1, 16'h0002, 1'b1, 1'b1);       // R7 write wins
    apply(1'b0, 16'h0, 1'b1, 1'b1);          // R3 2->1
    apply(1'b0, 16'h0, 1'b1, 1'b1);          // R4 1->0 fire
    apply(1'b0, 16'h0, 1'b1, 1'b1);          // R5/R8 no repeat
    apply(1'b1, 16'h0001, 1'b0, 1'b1);
    apply(1'b1, 16'h0001, 1'b1, 1'b1);       // R7 collision at one: no break
    apply(1'b0, 16'h0, 1'b1, 1'b1);          // R4 fire
    apply(1'b1, 16'h0000, 1'b0, 1'b1);       // programmed zero
    apply(1'b0, 16'h0, 1'b1, 1'b1);          // R5
    apply(1'b1, 16'hFFFF, 1'b0, 1'b0);       // R2 max count 4095
    apply(1'b0, 16'h0, 1'b1, 1'b1);          // R3 4095->4094

    // Constrained random, fixed seed
    void'($urandom(32'h5EED_0C4B));
    for (int i = 0; i < 4000; i++) begin
      logic        w, m, e;
      logic [15:0] d;
      int unsigned r;
      r = $urandom_range(0, 99);
      w = (r < 8);
      r = $urandom_range(0, 3);
      case (r)
        0: d = 16'h0000;
        1: d = 16'h0001 | ({$urandom_range(0, 15)} << 12);
        2: d = 16'(($urandom_range(0, 15) << 12) | $urandom_range(2, 6));
        default: d = 16'($urandom);
      endcase
      m = ($urandom_range(0, 99) < 70);
      e = ($urandom_range(0, 99) < 85);
      apply(w, d, m, e);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule